// File: doc/BRIEF.md
# PAL Line-Alternation Chroma Combiner

This block sits after a quadrature chroma demodulator in a PAL decoder. It receives B-Y and R-Y samples that have already been demodulated. The R-Y carrier was transmitted with its phase reversed on every other line, so on those lines the demodulated R-Y sample comes out with the wrong sign. The block keeps a line-phase flip-flop that toggles on every line-start strobe. The flip-flop is kept in step with the swing of the colour burst, which a per-line indicator reports. On the reversed lines the block flips the sign of R-Y.

The block holds a one-line memory of corrected B-Y and R-Y samples. In averaging mode, each output is the mean of the current sample and the stored sample at the same position on the line before. This cancels phase errors between adjacent lines digitally, so no analog delay line is needed. In simple mode, the corrected current sample is passed through alone, and the viewer's eye does the two-line averaging.

Top module: `pal_chroma_combiner`

## Requirements
- R1: A synchronous active-high reset drives `valid_o`, `by_o` and `ry_o` to zero and clears every entry of the line memory to zero.
- R2: Each accepted sample produces exactly one output, with `valid_o` high on the next clock cycle. In all other cycles `valid_o` is low.
- R3: A sample is accepted only when all of the following hold:
  - `smp_vld_i` is high;
  - `line_start_i` is low in the same cycle;
  - at least one line strobe has occurred since reset;
  - fewer than `DEPTH` samples of the current line have been accepted.
  Any other sample produces no output.
- R4: The line-phase state inverts at every line strobe. Its reset value makes the first line after reset non-inverted, with phase 0.
- R5: At each strobe, the predicted phase (the inverse of the present phase) is compared with `burst_inv_i`, where 1 means "this line is reversed".
  - A single disagreement leaves the prediction in force.
  - If there is a disagreement on two consecutive strobes, the second line takes the value of `burst_inv_i` and the disagreement history is cleared.
- R6: On reversed lines (phase 1) the R-Y sample is negated. The most negative code saturates to the most positive code. B-Y is never negated.
- R7: With `mode_avg_i` = 1, each output component is (corrected current + stored) / 2, rounded toward zero.
- R8: With `mode_avg_i` = 0 (simple mode), each output component is the corrected current sample alone.
- R9: Every accepted sample writes its corrected value into the line memory at its position on the line (0 for the first sample after a strobe). This happens in both modes.
- R10: On the first line after reset the outputs are never averaged. A position that the previous line did not reach keeps its older content, which is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start_i | input | 1 | One-cycle strobe that opens a new line |
| burst_inv_i | input | 1 | Burst phase for the line being opened: 1 = R-Y reversed; sampled with the strobe |
| mode_avg_i | input | 1 | 1 = two-line average, 0 = simple mode |
| smp_vld_i | input | 1 | Sample strobe for `by_i` / `ry_i` |
| by_i | input | CHROMA_W | Demodulated B-Y sample, two's complement |
| ry_i | input | CHROMA_W | Demodulated R-Y sample, two's complement |
| valid_o | output | 1 | Output sample valid |
| by_o | output | CHROMA_W | Combined B-Y |
| ry_o | output | CHROMA_W | Combined, sign-corrected R-Y |

## Verification
The hardest case to reach from the ports is the forced resynchronisation of the line phase. It needs the burst indicator to contradict the toggling prediction on exactly two strobes in a row, and the outcome is visible only through the sign of R-Y on the line that follows. The stimulus reaches it in two ways. A directed pair of strobes sets the burst bit equal to the present phase, which always disagrees with the prediction. Random lines also inject occasional burst glitches, including back-to-back ones, and a line-level model tracks the disagreement history.

A second hard case is reading cleared memory. After a reset, a short line followed by a longer line shows the zeroed entries through the halved averages at the tail of the second line.

// File: rtl/pal_comb_pkg.sv
package pal_comb_pkg;

    localparam int CHROMA_W = 10;

    typedef logic signed [CHROMA_W-1:0] chroma_t;

    typedef struct packed {
        chroma_t by;
        chroma_t ry;
    } cd_pair_t;

    typedef enum logic {
        MIX_SIMPLE  = 1'b0,
        MIX_AVERAGE = 1'b1
    } mix_mode_e;

    typedef struct packed {
        logic inv;   // 1 = R-Y reversed on the current line
        logic miss;  // previous strobe disagreed with the burst
    } phase_st_t;

    localparam chroma_t CHROMA_MAX = {1'b0, {(CHROMA_W-1){1'b1}}};
    localparam chroma_t CHROMA_MIN = {1'b1, {(CHROMA_W-1){1'b0}}};

    // Negation with the single overflow case clamped.
    function automatic chroma_t neg_sat(chroma_t a);
        chroma_t r;
        if (a == CHROMA_MIN) r = CHROMA_MAX;
        else                 r = -a;
        return r;
    endfunction

    // Mean of two codes, truncated toward zero.
    function automatic chroma_t half_sum(chroma_t a, chroma_t b);
        logic [CHROMA_W:0] s;
        s = {a[CHROMA_W-1], a} + {b[CHROMA_W-1], b};
        s = s + {{CHROMA_W{1'b0}}, s[CHROMA_W] & s[0]};
        return chroma_t'(s[CHROMA_W:1]);
    endfunction

endpackage

// File: rtl/pal_line_phase.sv
module pal_line_phase
    import pal_comb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic burst_inv,
    output logic line_inv
);
    phase_st_t st_q, st_d;
    logic      predict;
    logic      disagree;

    always_comb begin
        predict  = ~st_q.inv;
        disagree = (predict != burst_inv);
        st_d     = st_q;
        if (strobe) begin
            if (disagree && st_q.miss) begin
                st_d.inv  = burst_inv;
                st_d.miss = 1'b0;
            end else begin
                st_d.inv  = predict;
                st_d.miss = disagree;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.inv  <= 1'b1;   // first strobe lands on a non-reversed line
            st_q.miss <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_inv = st_q.inv;
endmodule

// File: rtl/pal_line_store.sv
module pal_line_store
    import pal_comb_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     strobe,
    input  logic     smp_vld,
    input  cd_pair_t wr_data,
    output cd_pair_t rd_data,
    output logic     accept,
    output logic     have_prev
);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int IDX_W = $clog2(DEPTH + 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH);

    cd_pair_t         mem [DEPTH];
    logic [IDX_W-1:0] pos_q;
    logic             seen_q;
    logic [AW-1:0]    addr;
    logic             in_range;

    assign in_range = (pos_q < LAST);
    assign addr     = AW'(pos_q);
    assign accept   = smp_vld && !strobe && seen_q && in_range;
    assign rd_data  = in_range ? mem[addr] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q     <= '0;
            seen_q    <= 1'b0;
            have_prev <= 1'b0;
        end else if (strobe) begin
            pos_q     <= '0;
            seen_q    <= 1'b1;
            have_prev <= seen_q;
        end else if (accept) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (accept) begin
            mem[addr] <= wr_data;
        end
    end
endmodule

// File: rtl/pal_line_mix.sv
module pal_line_mix
    import pal_comb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      accept,
    input  logic      line_inv,
    input  logic      have_prev,
    input  mix_mode_e mode,
    input  cd_pair_t  cur,
    input  cd_pair_t  prev,
    output cd_pair_t  corr,
    output logic      out_vld,
    output cd_pair_t  out_q
);
    cd_pair_t mixed;

    always_comb begin
        corr.by = cur.by;
        corr.ry = line_inv ? neg_sat(cur.ry) : cur.ry;
    end

    always_comb begin
        if (mode == MIX_AVERAGE && have_prev) begin
            mixed.by = half_sum(corr.by, prev.by);
            mixed.ry = half_sum(corr.ry, prev.ry);
        end else begin
            mixed = corr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_q   <= '0;
        end else begin
            out_vld <= accept;
            if (accept) out_q <= mixed;
        end
    end
endmodule

// File: rtl/pal_chroma_combiner.sv
module pal_chroma_combiner
    import pal_comb_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       line_start_i,
    input  logic                       burst_inv_i,
    input  logic                       mode_avg_i,
    input  logic                       smp_vld_i,
    input  logic signed [CHROMA_W-1:0] by_i,
    input  logic signed [CHROMA_W-1:0] ry_i,
    output logic                       valid_o,
    output logic signed [CHROMA_W-1:0] by_o,
    output logic signed [CHROMA_W-1:0] ry_o
);
    logic     line_inv;
    logic     accept;
    logic     have_prev;
    cd_pair_t cur, prev, corr, out_q;

    assign cur.by = by_i;
    assign cur.ry = ry_i;

    pal_line_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .strobe    (line_start_i),
        .burst_inv (burst_inv_i),
        .line_inv  (line_inv)
    );

    pal_line_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .strobe    (line_start_i),
        .smp_vld   (smp_vld_i),
        .wr_data   (corr),
        .rd_data   (prev),
        .accept    (accept),
        .have_prev (have_prev)
    );

    pal_line_mix u_mix (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .line_inv  (line_inv),
        .have_prev (have_prev),
        .mode      (mix_mode_e'(mode_avg_i)),
        .cur       (cur),
        .prev      (prev),
        .corr      (corr),
        .out_vld   (valid_o),
        .out_q     (out_q)
    );

    assign by_o = out_q.by;
    assign ry_o = out_q.ry;
endmodule

// File: rtl/pal_chroma_combiner_chk.sv
module pal_chroma_combiner_chk
    import pal_comb_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       line_start_i,
    input logic                       burst_inv_i,
    input logic                       mode_avg_i,
    input logic                       smp_vld_i,
    input logic signed [CHROMA_W-1:0] by_i,
    input logic signed [CHROMA_W-1:0] ry_i,
    input logic                       valid_o,
    input logic signed [CHROMA_W-1:0] by_o,
    input logic signed [CHROMA_W-1:0] ry_o,
    input logic                       line_inv
);
    // R4: the phase only moves on a strobe
    assert_phase_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !line_start_i |=> $stable(line_inv));

    // R5: a strobe either inverts the phase or takes the burst value
    assert_phase_step_R5: assert property (@(posedge clk) disable iff (rst)
        line_start_i |=> (line_inv != $past(line_inv)) || (line_inv == $past(burst_inv_i)));

    // R2: an output needs a sample outside a strobe cycle one cycle earlier
    assert_valid_source_R2: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(smp_vld_i && !line_start_i));

    // R8: simple mode never alters B-Y
    assert_simple_by_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(!mode_avg_i)) |-> by_o == $past(by_i));

    // R6: simple mode on a non-reversed line passes R-Y unchanged
    assert_simple_ry_R6: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(!mode_avg_i && !line_inv)) |-> ry_o == $past(ry_i));
endmodule

bind pal_chroma_combiner pal_chroma_combiner_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .line_start_i (line_start_i),
    .burst_inv_i  (burst_inv_i),
    .mode_avg_i   (mode_avg_i),
    .smp_vld_i    (smp_vld_i),
    .by_i         (by_i),
    .ry_i         (ry_i),
    .valid_o      (valid_o),
    .by_o         (by_o),
    .ry_o         (ry_o),
    .line_inv     (line_inv)
);

// File: tb/sim_pal_chroma_combiner.sv
module sim_pal_chroma_combiner;
    localparam int W     = pal_comb_pkg::CHROMA_W;
    localparam int DEPTH = 12;
    localparam int VMAX  = (1 << (W - 1)) - 1;
    localparam int VMIN  = -(1 << (W - 1));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_start_i = 1'b0, burst_inv_i = 1'b0, mode_avg_i = 1'b0, smp_vld_i = 1'b0;
    logic signed [W-1:0] by_i = '0, ry_i = '0;
    logic valid_o;
    logic signed [W-1:0] by_o, ry_o;

    int n_chk = 0, n_err = 0;

    // bench line model
    bit m_inv, m_miss, m_seen, m_have;
    int m_pos;
    int st_by [DEPTH];
    int st_ry [DEPTH];

    always #2 clk = ~clk;

    pal_chroma_combiner #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .line_start_i(line_start_i), .burst_inv_i(burst_inv_i),
        .mode_avg_i(mode_avg_i), .smp_vld_i(smp_vld_i), .by_i(by_i), .ry_i(ry_i),
        .valid_o(valid_o), .by_o(by_o), .ry_o(ry_o)
    );

    function automatic int m_neg(int v);
        return (v == VMIN) ? VMAX : -v;
    endfunction

    function automatic int m_mean(int a, int b);
        return (a + b) / 2;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        m_inv = 1'b1; m_miss = 1'b0; m_seen = 1'b0; m_have = 1'b0; m_pos = 0;
        for (int i = 0; i < DEPTH; i++) begin st_by[i] = 0; st_ry[i] = 0; end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; line_start_i = 0; smp_vld_i = 0;
        model_clear();
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 valid", int'(valid_o), 0);
        check("R1 by", int'(by_o), 0);
        check("R1 ry", int'(ry_o), 0);
    endtask

    // One cycle: drive at a falling edge, check at the next falling edge.
    task automatic cycle(bit ls, bit burst, bit vld, int b, int r, bit mode, string tag);
        bit exp_v = 1'b0;
        int eb = 0, er = 0;
        line_start_i = ls; burst_inv_i = burst; smp_vld_i = vld; mode_avg_i = mode;
        by_i = W'(b); ry_i = W'(r);
        if (ls) begin
            bit pred = ~m_inv;
            bit dis  = (pred != burst);
            if (dis && m_miss) begin m_inv = burst; m_miss = 1'b0; end
            else begin m_inv = pred; m_miss = dis; end
            m_have = m_seen; m_seen = 1'b1; m_pos = 0;
        end else if (vld && m_seen && m_pos < DEPTH) begin
            int cb = b;
            int cr = m_inv ? m_neg(r) : r;
            exp_v = 1'b1;
            if (mode && m_have) begin
                eb = m_mean(cb, st_by[m_pos]);
                er = m_mean(cr, st_ry[m_pos]);
            end else begin
                eb = cb; er = cr;
            end
            st_by[m_pos] = cb; st_ry[m_pos] = cr;
            m_pos++;
        end
        @(negedge clk);
        check(exp_v ? "R2 valid" : "R3 valid", int'(valid_o), int'(exp_v));
        if (exp_v) begin
            check({tag, " by"}, int'(by_o), eb);
            check({tag, " ry"}, int'(ry_o), er);
        end
    endtask

    task automatic idle();
        cycle(0, 0, 0, 0, 0, 0, "R2");
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : main
        int r;
        bit true_ph;
        void'($urandom(32'd1234));
        model_clear();
        do_reset();

        // R3: samples before any strobe are dropped
        cycle(0, 0, 1, 5, 7, 1, "R3");
        cycle(0, 0, 1, -5, 9, 0, "R3");

        // R4 / R10: first line, non-reversed, never averaged
        cycle(1, 0, 0, 0, 0, 1, "R4");
        cycle(0, 0, 1, 100, 60, 1, "R10");
        cycle(0, 0, 1, -40, -33, 1, "R10");
        cycle(0, 0, 1, 17, 3, 1, "R10");
        // R1 / R10: longer reversed line reads zeroed tail entries
        cycle(1, 1, 0, 0, 0, 1, "R4");
        for (int i = 0; i < 6; i++) cycle(0, 0, 1, 11 * i - 25, 7 - 13 * i, 1, "R1");

        // R6: most negative R-Y on a non-reversed then reversed line, simple mode
        cycle(1, 0, 0, 0, 0, 0, "R4");
        cycle(0, 0, 1, VMIN, VMIN, 0, "R6");
        cycle(1, 1, 0, 0, 0, 0, "R4");
        cycle(0, 0, 1, VMIN, VMIN, 0, "R6");
        cycle(0, 0, 1, VMAX, VMAX, 0, "R6");

        // R3: sample during strobe ignored; overlong line truncated
        cycle(1, 0, 1, 50, 50, 1, "R3");
        for (int i = 0; i < DEPTH + 3; i++) cycle(0, 0, 1, i * 9 - 60, 55 - i * 7, 1, "R7");

        // R9: simple-mode line still loads the store; averaged line reads it
        cycle(1, 1, 0, 0, 0, 0, "R4");
        for (int i = 0; i < 4; i++) cycle(0, 0, 1, 3 * i + 1, -5 * i - 1, 0, "R8");
        cycle(1, 0, 0, 0, 0, 1, "R4");
        for (int i = 0; i < 4; i++) cycle(0, 0, 1, -7 * i, 9 * i + 2, 1, "R9");

        // R5: single disagreement, then two in a row
        cycle(1, m_inv, 0, 0, 0, 0, "R5");
        cycle(0, 0, 1, 10, 100, 0, "R5");
        cycle(1, m_inv, 0, 0, 0, 0, "R5");
        cycle(0, 0, 1, 10, 100, 0, "R5");
        cycle(1, ~m_inv, 0, 0, 0, 0, "R5");
        cycle(0, 0, 1, 10, 100, 0, "R5");

        // R1: reset mid-stream empties the store
        do_reset();
        cycle(1, 0, 0, 0, 0, 1, "R4");
        cycle(0, 0, 1, 40, 40, 1, "R10");
        cycle(0, 0, 1, 40, 40, 1, "R10");
        cycle(1, 1, 0, 0, 0, 1, "R4");
        for (int i = 0; i < 4; i++) cycle(0, 0, 1, 81, -81, 1, "R1");

        // random lines with burst glitches, gaps, mode changes
        true_ph = m_inv;
        for (int ln = 0; ln < 400; ln++) begin
            bit mode = ($urandom % 4) != 0;
            int len  = 1 + ($urandom % (DEPTH + 2));
            bit burst;
            true_ph = ~true_ph;
            burst = true_ph;
            if (($urandom % 8) == 0) burst = ~burst;
            cycle(1, burst, ($urandom % 2) == 1, 1, 1, mode, "R5");
            for (int s = 0; s < len; s++) begin
                if (($urandom % 5) == 0) idle();
                r = $urandom;
                cycle(0, 0, 1, int'($signed(W'(r))), int'($signed(W'(r >> 12))),
                      mode, mode ? "R7" : "R8");
            end
            if (($urandom % 20) == 0) true_ph = m_inv;
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule